// File: doc/BRIEF.md
# Shared RAM Bus Arbiter for Host and Serial Terminal

This block decides who owns a shared address/data bus and its external RAM: a host processor or a serial-bus protocol terminal. A host cycle begins on the rising edge of select-and-strobe. The block then waits a fixed two-clock lag and enables the external buffers. It drives the RAM or the register-side strobes for two clocks and ends the cycle with a one-clock ready pulse.

The terminal asks for the bus with a request line and receives a grant. It takes ownership once it returns an acknowledge. From then on, its own chip-select, output-enable and write lines pass straight through to the RAM. A host strobe that arrives while the terminal holds the bus is remembered. The host cycle then starts with the same two-clock lag, counted from the clock edge at which the terminal releases the bus.

A master-clear input resets all state at once. A low pulse on the superseding-command input aborts whatever transfer is in progress. A reset output for external devices is low whenever master clear is low or the host asks for a reset.

Top module: `hostbus_arbiter`

## Requirements
- R1: A host cycle starts only on a clock where `h_sel` and `h_strb` are both 1 and were not both 1 on the previous clock. Either line alone starts nothing, and `buf_en` stays 0.
- R2: With the bus free, `buf_en` goes to 1 in the second clock after the edge that samples the starting strobe. It stays 1 for three clocks: two access clocks and one ready clock.
- R3: If the terminal holds the grant when a host cycle starts, the cycle is kept pending. `buf_en` rises two clocks after the edge at which `t_req` is sampled 0, and the cycle then runs as in R2.
- R4: `t_grant` rises one clock after `t_req` is sampled 1 while the block is idle. The terminal owns the bus from the edge that samples `t_ack` 1 while granted. `t_grant` falls one clock after `t_req` is sampled 0.
- R5: While the terminal owns the bus, `mem_cs`, `mem_oe` and `mem_we` equal `t_cs`, `t_oe` and `t_we` combinationally.
- R6: `h_mem` (1 = RAM, 0 = register) and `h_rd` (1 = read, 0 = write) are captured with the starting strobe. During the two access clocks the block drives outputs as follows:
  - RAM read: `mem_cs` and `mem_oe`.
  - RAM write: `mem_cs` and `mem_we`.
  - Register read: `ext_oe` only.
  - Register write: `ext_ld` only.
- R7: `mclr_n` = 0 clears all state at once, without waiting for the clock. `buf_en`, `t_grant`, `h_ready` and all strobes go to 0.
- R8: A clock that samples `t_newseq_n` = 0 returns the block to idle and drops any pending host cycle. On the next clock `buf_en` and `t_grant` are 0, and no ready pulse follows.
- R9: `ext_rst_n` is 0 whenever `mclr_n` is 0 or `host_rst_req` is 1, and 1 otherwise.
- R10: `h_ready` is a one-clock pulse in the clock after the two access clocks. No strobe is active in that clock.
- R11: If a host cycle and `t_req` arrive on the same clock, the terminal is granted first and the host cycle follows its release. A host cycle that has already started completes before `t_grant` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mclr_n | input | 1 | Master clear, active low, asynchronous |
| host_rst_req | input | 1 | Host request to reset external devices |
| h_sel | input | 1 | Host select |
| h_strb | input | 1 | Host data strobe |
| h_mem | input | 1 | 1 = RAM cycle, 0 = register cycle |
| h_rd | input | 1 | 1 = read, 0 = write |
| h_ready | output | 1 | One-clock ready pulse to host |
| buf_en | output | 1 | External bus buffer enable |
| t_req | input | 1 | Terminal bus request |
| t_ack | input | 1 | Terminal acknowledge of grant |
| t_cs | input | 1 | Terminal memory chip-select |
| t_oe | input | 1 | Terminal memory output-enable |
| t_we | input | 1 | Terminal memory write |
| t_newseq_n | input | 1 | Superseding-command abort, active low |
| t_grant | output | 1 | Bus grant to terminal |
| mem_cs | output | 1 | RAM chip-select |
| mem_oe | output | 1 | RAM output-enable |
| mem_we | output | 1 | RAM write strobe |
| ext_oe | output | 1 | External register output enable |
| ext_ld | output | 1 | External register load |
| ext_rst_n | output | 1 | Reset to external devices, active low |

## Verification
The assertions assume a well-behaved terminal and host:
- The terminal holds `t_req` until the grant, and keeps `t_ack` high for as long as it owns the bus.
- The host pulses its strobe once per cycle and does not start a second cycle while one is running.

The stimulus keeps to these rules throughout. Every strobe is a single clock long, `t_ack` is raised only after `t_grant` is seen, and request and acknowledge drop together on release. Aborts and master clear are the only events applied in the middle of a cycle.

// File: rtl/hostbus_arbiter.sv
module hostbus_arbiter #(
  parameter int LAG_CYCLES = 2,
  parameter int ACC_CYCLES = 2
) (
  input  logic clk,
  input  logic mclr_n,
  input  logic host_rst_req,
  input  logic h_sel,
  input  logic h_strb,
  input  logic h_mem,
  input  logic h_rd,
  output logic h_ready,
  output logic buf_en,
  input  logic t_req,
  input  logic t_ack,
  input  logic t_cs,
  input  logic t_oe,
  input  logic t_we,
  input  logic t_newseq_n,
  output logic t_grant,
  output logic mem_cs,
  output logic mem_oe,
  output logic mem_we,
  output logic ext_oe,
  output logic ext_ld,
  output logic ext_rst_n
);
  localparam int MAXC = (LAG_CYCLES > ACC_CYCLES) ? LAG_CYCLES : ACC_CYCLES;
  localparam int CW = (MAXC > 2) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] LAG_LAST = CW'(LAG_CYCLES - 1);
  localparam logic [CW-1:0] ACC_LAST = CW'(ACC_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_LAG, S_ACC, S_DONE, S_GRANT, S_OWN} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic pend, strb_q, mem_q, rd_q;
  logic start, host_busy, own, host_act, go_host;

  assign start     = h_sel & h_strb & ~strb_q;
  assign host_busy = (st == S_LAG) | (st == S_ACC) | (st == S_DONE);
  assign own       = (st == S_OWN);
  assign host_act  = (st == S_ACC);
  assign go_host   = pend | start;

  always_ff @(posedge clk or negedge mclr_n) begin
    if (!mclr_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      pend   <= 1'b0;
      strb_q <= 1'b0;
      mem_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      strb_q <= h_sel & h_strb;
      if (start && !host_busy) begin
        mem_q <= h_mem;
        rd_q  <= h_rd;
      end
      if (!t_newseq_n) begin
        st   <= S_IDLE;
        cnt  <= '0;
        pend <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            if (t_req) begin
              st <= S_GRANT;
              if (start) pend <= 1'b1;
            end else if (go_host) begin
              st   <= S_LAG;
              cnt  <= '0;
              pend <= 1'b0;
            end
          end
          S_LAG: begin
            if (cnt == LAG_LAST) begin
              st  <= S_ACC;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_ACC: begin
            if (cnt == ACC_LAST) begin
              st  <= S_DONE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DONE: st <= S_IDLE;
          S_GRANT, S_OWN: begin
            if (!t_req) begin
              if (go_host) begin
                st   <= S_LAG;
                cnt  <= '0;
                pend <= 1'b0;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              if (start) pend <= 1'b1;
              if (st == S_GRANT && t_ack) st <= S_OWN;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign buf_en    = host_act | (st == S_DONE);
  assign h_ready   = (st == S_DONE);
  assign t_grant   = (st == S_GRANT) | own;
  assign mem_cs    = own ? t_cs : (host_act & mem_q);
  assign mem_oe    = own ? t_oe : (host_act & mem_q & rd_q);
  assign mem_we    = own ? t_we : (host_act & mem_q & ~rd_q);
  assign ext_oe    = host_act & ~mem_q & rd_q;
  assign ext_ld    = host_act & ~mem_q & ~rd_q;
  assign ext_rst_n = mclr_n & ~host_rst_req;
endmodule

// File: rtl/hostbus_arbiter_props.sv
module hostbus_arbiter_props (
  input logic clk,
  input logic mclr_n,
  input logic h_ready,
  input logic buf_en,
  input logic t_req,
  input logic t_ack,
  input logic t_cs,
  input logic t_oe,
  input logic t_we,
  input logic t_newseq_n,
  input logic t_grant,
  input logic mem_cs,
  input logic mem_oe,
  input logic mem_we
);
  a_r2_lag_after_release: assert property (@(posedge clk) disable iff (!mclr_n)
    $rose(buf_en) |-> !t_grant && $past(!t_grant));

  a_r4_grant_needs_req: assert property (@(posedge clk) disable iff (!mclr_n)
    $rose(t_grant) |-> $past(t_req));

  a_r4_grant_drops: assert property (@(posedge clk) disable iff (!mclr_n)
    t_grant && !t_req |=> !t_grant);

  a_r5_routing: assert property (@(posedge clk) disable iff (!mclr_n)
    t_grant && $past(t_grant && t_ack) |-> mem_cs == t_cs && mem_oe == t_oe && mem_we == t_we);

  a_r6_write_width: assert property (@(posedge clk) disable iff (!mclr_n)
    $rose(mem_we) && !t_grant && t_newseq_n |=> mem_we);

  a_r8_abort: assert property (@(posedge clk) disable iff (!mclr_n)
    !t_newseq_n |=> !buf_en && !t_grant);

  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!mclr_n)
    h_ready |=> !h_ready);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!mclr_n)
    !(buf_en && t_grant));
endmodule

bind hostbus_arbiter hostbus_arbiter_props u_props (
  .clk(clk), .mclr_n(mclr_n), .h_ready(h_ready), .buf_en(buf_en),
  .t_req(t_req), .t_ack(t_ack), .t_cs(t_cs), .t_oe(t_oe), .t_we(t_we),
  .t_newseq_n(t_newseq_n), .t_grant(t_grant),
  .mem_cs(mem_cs), .mem_oe(mem_oe), .mem_we(mem_we)
);

// File: tb/hostbus_arbiter_test.sv
module hostbus_arbiter_test;
  logic clk = 1'b0;
  logic mclr_n = 1'b0, host_rst_req = 1'b0;
  logic h_sel = 1'b0, h_strb = 1'b0, h_mem = 1'b0, h_rd = 1'b0;
  logic t_req = 1'b0, t_ack = 1'b0, t_cs = 1'b0, t_oe = 1'b0, t_we = 1'b0;
  logic t_newseq_n = 1'b1;
  logic h_ready, buf_en, t_grant, mem_cs, mem_oe, mem_we, ext_oe, ext_ld, ext_rst_n;
  logic [4:0] obs;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hostbus_arbiter uut (
    .clk(clk), .mclr_n(mclr_n), .host_rst_req(host_rst_req),
    .h_sel(h_sel), .h_strb(h_strb), .h_mem(h_mem), .h_rd(h_rd),
    .h_ready(h_ready), .buf_en(buf_en),
    .t_req(t_req), .t_ack(t_ack), .t_cs(t_cs), .t_oe(t_oe), .t_we(t_we),
    .t_newseq_n(t_newseq_n), .t_grant(t_grant),
    .mem_cs(mem_cs), .mem_oe(mem_oe), .mem_we(mem_we),
    .ext_oe(ext_oe), .ext_ld(ext_ld), .ext_rst_n(ext_rst_n)
  );

  assign obs = {mem_cs, mem_oe, mem_we, ext_oe, ext_ld};

  // {h_mem, h_rd, expected {mem_cs, mem_oe, mem_we, ext_oe, ext_ld}}
  localparam logic [6:0] VEC [4] = '{
    7'b11_11000, 7'b10_10100, 7'b01_00010, 7'b00_00001
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic strobe(input logic m, input logic r);
    h_mem = m; h_rd = r; h_sel = 1'b1; h_strb = 1'b1;
    step();
    h_sel = 1'b0; h_strb = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) step();
    chk("R7 reset buf_en", buf_en, 0);
    chk("R7 reset grant", t_grant, 0);
    chk("R7 reset ready", h_ready, 0);
    chk("R7 reset strobes", obs, 0);
    chk("R9 ext_rst_n under clear", ext_rst_n, 0);
    mclr_n = 1'b1;
    step();
    chk("R9 ext_rst_n released", ext_rst_n, 1);

    // R1: one qualifier alone starts nothing
    h_strb = 1'b1; step(); h_strb = 1'b0;
    for (int j = 0; j < 4; j++) begin step(); chk("R1 strobe alone", buf_en, 0); end
    h_sel = 1'b1; step(); h_sel = 1'b0;
    for (int j = 0; j < 4; j++) begin step(); chk("R1 select alone", buf_en, 0); end

    // Vector table: four cycle kinds on a free bus
    for (int i = 0; i < 4; i++) begin
      strobe(VEC[i][6], VEC[i][5]);
      h_mem = ~VEC[i][6]; h_rd = ~VEC[i][5];
      chk("R2 no enable at k", buf_en, 0);
      step(); chk("R2 no enable at k+1", buf_en, 0);
      step(); chk("R2 enable at k+2", buf_en, 1);
      chk("R6 strobes first clock", obs, {27'd0, VEC[i][4:0]});
      chk("R10 no early ready", h_ready, 0);
      step(); chk("R6 strobes second clock", obs, {27'd0, VEC[i][4:0]});
      step(); chk("R10 ready pulse", h_ready, 1);
      chk("R10 strobes idle at ready", obs, 0);
      chk("R2 enable held at ready", buf_en, 1);
      step(); chk("R10 ready single clock", h_ready, 0);
      chk("R2 enable released", buf_en, 0);
    end

    // R4/R5/R3: terminal ownership, held host cycle
    t_req = 1'b1; step();
    chk("R4 grant after request", t_grant, 1);
    chk("R4 no routing before ack", obs, 0);
    t_ack = 1'b1; t_cs = 1'b1; t_oe = 1'b1; step();
    chk("R5 routed read", obs, 5'b11000);
    t_oe = 1'b0; t_we = 1'b1; #1;
    chk("R5 routed write", obs, 5'b10100);
    strobe(1'b1, 1'b1);
    step(); chk("R3 held off", buf_en, 0);
    step(); chk("R3 still held", buf_en, 0);
    t_req = 1'b0; t_ack = 1'b0; t_cs = 1'b0; t_we = 1'b0;
    step(); chk("R4 grant dropped", t_grant, 0);
    chk("R3 no enable at release", buf_en, 0);
    step(); chk("R3 no enable at r+1", buf_en, 0);
    step(); chk("R3 enable at r+2", buf_en, 1);
    chk("R3 pending read strobes", obs, 5'b11000);
    repeat (3) step();
    chk("R3 cycle complete", buf_en, 0);

    // R11: same-clock arrival, terminal wins
    t_req = 1'b1;
    strobe(1'b0, 1'b0);
    chk("R11 terminal wins tie", t_grant, 1);
    chk("R11 host waits", buf_en, 0);
    t_ack = 1'b1; step(); step();
    t_req = 1'b0; t_ack = 1'b0;
    step(); step(); step();
    chk("R11 host follows release", buf_en, 1);
    chk("R11 register write strobe", obs, 5'b00001);
    repeat (3) step();

    // R11: started host cycle completes before grant
    strobe(1'b1, 1'b0);
    t_req = 1'b1;
    for (int j = 1; j <= 5; j++) begin step(); chk("R11 grant deferred", t_grant, 0); end
    step(); chk("R11 grant after host done", t_grant, 1);
    t_req = 1'b0; step();
    chk("R4 grant released", t_grant, 0);

    // R8: abort of host cycle and of ownership
    strobe(1'b1, 1'b1);
    step();
    t_newseq_n = 1'b0; step(); t_newseq_n = 1'b1;
    chk("R8 host aborted", buf_en, 0);
    for (int j = 0; j < 4; j++) begin
      step();
      chk("R8 no enable after abort", buf_en, 0);
      chk("R8 no ready after abort", h_ready, 0);
    end
    t_req = 1'b1; step(); t_ack = 1'b1; step();
    chk("R4 owned before abort", t_grant, 1);
    t_newseq_n = 1'b0; step();
    chk("R8 grant aborted", t_grant, 0);
    t_newseq_n = 1'b1; t_req = 1'b0; t_ack = 1'b0;
    step(); step();

    // R7: asynchronous master clear mid-cycle
    strobe(1'b1, 1'b0);
    step(); step();
    chk("R7 cycle active before clear", buf_en, 1);
    mclr_n = 1'b0; #1;
    chk("R7 enable cleared", buf_en, 0);
    chk("R7 strobes cleared", obs, 0);
    chk("R9 ext_rst_n on clear", ext_rst_n, 0);
    step(); mclr_n = 1'b1; step();
    chk("R7 stays idle", buf_en, 0);

    // R9: host reset request
    host_rst_req = 1'b1; #1;
    chk("R9 host reset drives low", ext_rst_n, 0);
    host_rst_req = 1'b0; #1;
    chk("R9 host reset released", ext_rst_n, 1);

    step();
    finish_run();
  end
endmodule